// File: doc/BRIEF.md
# Round Subkey Generator for a 64-bit Lightweight Feistel Cipher

This block derives the 128 one-byte round subkeys that the cipher's 32 rounds use. A 7-bit shift register with linear feedback produces a new pseudo-random constant for every subkey. Each constant is zero-extended to a byte and added modulo 256 to one byte of the 128-bit master key. The byte is chosen by a rule that rotates through the two halves of the key. The encryption core sees four subkey bytes at a time, belonging to the round shown on `round_idx`. It moves to the next round by pulsing `advance`.

A parameter picks one of two build variants. The on-the-fly variant computes the four bytes of the current round from the live constant register, so it is usable in the cycle after the key is loaded. The banked variant spends one cycle per round filling a small register bank after a load. From then on it serves rounds from storage, and replaying a block costs no regeneration. Both variants wrap from the last round back to round 0 with the subkey sequence restarted, so several blocks can be processed under one key without reloading.

Top module: `rsk_gen`

## Requirements
- R1: After reset and before the first load, `ready` is 0 and `round_idx` is 0.
- R2: The constant sequence starts at 7'h5A. Each next constant is {c[3]^c[0], c[6:1]}, and subkey n uses constant n. With an all-zero key, SK0 and SK127 both equal 8'h5A, because the sequence has period 127.
- R3: Byte k of `sk_out` (bits 8k+7..8k) carries subkey SK(4r+k), where r is the value on `round_idx`.
- R4: Each subkey is (key byte + {1'b0, constant}) mod 256. Key byte b is `key_in[8b+7:8b]` as captured at the load.
- R5: For i, j in 0..7, SK(16i+j) uses key byte (j-i) mod 8, and SK(16i+j+8) uses key byte ((j-i) mod 8)+8.
- R6: A `load` pulse captures `key_in`, sets `round_idx` to 0 and restarts the constant sequence. This holds even in the middle of a pass. In the on-the-fly variant `ready` is 1 in the next cycle. In the banked variant `ready` is 0 until the 32nd rising edge after the edge that samples `load`, and 1 from that edge on.
- R7: `advance` while `ready` is 1 moves `round_idx` up by one. From round 31 it returns to round 0, whose subkeys are again SK0..SK3.
- R8: `advance` while `ready` is 0 is ignored. This covers the time before the first load and the banked fill, and `round_idx` does not move.
- R9: Without `advance` or `load`, `round_idx`, `sk_out` and `ready` hold their values.
- R10: Changing `key_in` without a `load` does not affect `sk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture key and restart the subkey sequence |
| key_in | input | 128 | Master key, byte b at bits 8b+7..8b |
| advance | input | 1 | Step to the next round's subkeys |
| ready | output | 1 | Subkeys on sk_out are valid for round_idx |
| round_idx | output | 5 | Round whose subkeys are presented |
| sk_out | output | 32 | Four subkeys, byte k = SK(4*round_idx+k) |

## Verification
A constant register that slips by even one step corrupts every later subkey. With an all-zero key the error appears in the first round examined, because the subkey bytes are then the raw constants. A wrong key byte selection shows only in the lanes whose byte index differs. Keys with distinct byte values are therefore swept through all 32 rounds and the wrap, so a selection fault is exposed within the 16 subkeys that make up one full rotation. Fill-counter or ready faults in the banked variant show up as a shift of one cycle on `ready` or as a round with stale data, and the bench checks the exact edge on which `ready` rises.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

   localparam int CW = 7;
   localparam int BW = 8;
   localparam int KEY_BYTES = 16;
   localparam int SUBKEY_IDX_W = 7;
   localparam logic [CW-1:0] CONST_SEED = 7'h5A;

   // one step of the x^7 + x^3 + 1 sequence: shift right, feed bit3^bit0 into msb
   function automatic logic [CW-1:0] lfsr_next(input logic [CW-1:0] c);
      return {c[3] ^ c[0], c[CW-1:1]};
   endfunction

   // key byte index for subkey n: low half or high half picked by n[3],
   // rotation (j - i) mod 8 with j = n[2:0], i = n[6:4]
   function automatic logic [3:0] key_byte_sel(input logic [SUBKEY_IDX_W-1:0] n);
      logic [2:0] rot;
      rot = n[2:0] - n[6:4];
      return {n[3], rot};
   endfunction

endpackage

// File: rtl/rsk_lfsr.sv
module rsk_lfsr
   import rsk_pkg::*;
#(
   parameter int LANES = 4,
   parameter logic [CW-1:0] SEED = CONST_SEED
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic                      step,
   output logic [LANES-1:0][CW-1:0]  csts
);

   logic [CW-1:0]            state_q;
   logic [LANES:0][CW-1:0]   chain;

   assign chain[0] = state_q;

   for (genvar k = 0; k < LANES; k++) begin : g_chain
      assign chain[k+1] = lfsr_next(chain[k]);
      assign csts[k]    = chain[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (restart) begin
         state_q <= SEED;
      end else if (step) begin
         state_q <= chain[LANES];
      end
   end

endmodule

// File: rtl/rsk_lane.sv
module rsk_lane
   import rsk_pkg::*;
(
   input  logic [KEY_BYTES*BW-1:0]   key,
   input  logic [SUBKEY_IDX_W-1:0]   idx,
   input  logic [CW-1:0]             cst,
   output logic [BW-1:0]             sk
);

   logic [3:0]    sel;
   logic [BW-1:0] kbyte;

   assign sel   = key_byte_sel(idx);
   assign kbyte = key[{sel, 3'b000} +: BW];
   assign sk    = kbyte + {1'b0, cst};

endmodule

// File: rtl/rsk_bank.sv
module rsk_bank #(
   parameter int DEPTH = 32,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rsk_gen.sv
module rsk_gen
   import rsk_pkg::*;
#(
   parameter bit              BANK       = 1'b0,
   parameter int              NUM_ROUNDS = 32,
   parameter int              LANES      = 4,
   parameter logic [CW-1:0]   SEED       = CONST_SEED,
   localparam int             RW         = $clog2(NUM_ROUNDS),
   localparam int             LW         = $clog2(LANES),
   localparam int             OW         = LANES * BW,
   localparam int             KW         = KEY_BYTES * BW
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [KW-1:0]  key_in,
   input  logic           advance,
   output logic           ready,
   output logic [RW-1:0]  round_idx,
   output logic [OW-1:0]  sk_out
);

   // elaboration checks
   if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
      $error("rsk_gen: LANES must be a power of two, at least 2");
   end
   if (NUM_ROUNDS < 2 || (1 << RW) != NUM_ROUNDS) begin : g_bad_rounds
      $error("rsk_gen: NUM_ROUNDS must be a power of two, at least 2");
   end
   if (RW + LW > SUBKEY_IDX_W) begin : g_bad_total
      $error("rsk_gen: NUM_ROUNDS*LANES exceeds the 128-subkey index space");
   end

   localparam logic [RW-1:0] LAST_ROUND = RW'(NUM_ROUNDS - 1);

   logic [KW-1:0]                     key_q;
   logic [RW-1:0]                     gen_round;
   logic                              lfsr_restart;
   logic                              lfsr_step;
   logic [LANES-1:0][CW-1:0]          cst;
   logic [LANES-1:0][SUBKEY_IDX_W-1:0] sub_idx;
   logic [OW-1:0]                     gen_sk;
   logic                              gen_last;

   assign gen_last = (gen_round == LAST_ROUND);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (load) begin
         key_q <= key_in;
      end
   end

   rsk_lfsr #(
      .LANES (LANES),
      .SEED  (SEED)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (lfsr_restart),
      .step    (lfsr_step),
      .csts    (cst)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign sub_idx[k] = SUBKEY_IDX_W'({gen_round, LW'(k)});
      rsk_lane u_lane (
         .key (key_q),
         .idx (sub_idx[k]),
         .cst (cst[k]),
         .sk  (gen_sk[k*BW +: BW])
      );
   end

   if (BANK) begin : g_banked
      logic           filling;
      logic           full;
      logic [RW-1:0]  rd_round;
      logic [OW-1:0]  bank_q;
      logic           fill_we;

      assign fill_we      = filling & ~load;
      assign lfsr_restart = load;
      assign lfsr_step    = fill_we;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            filling   <= 1'b0;
            full      <= 1'b0;
            gen_round <= '0;
            rd_round  <= '0;
         end else if (load) begin
            filling   <= 1'b1;
            full      <= 1'b0;
            gen_round <= '0;
            rd_round  <= '0;
         end else if (filling) begin
            gen_round <= gen_last ? '0 : gen_round + 1'b1;
            if (gen_last) begin
               filling <= 1'b0;
               full    <= 1'b1;
            end
         end else if (advance && full) begin
            rd_round <= (rd_round == LAST_ROUND) ? '0 : rd_round + 1'b1;
         end
      end

      rsk_bank #(
         .DEPTH (NUM_ROUNDS),
         .WIDTH (OW)
      ) u_bank (
         .clk   (clk),
         .we    (fill_we),
         .waddr (gen_round),
         .wdata (gen_sk),
         .raddr (rd_round),
         .rdata (bank_q)
      );

      assign ready     = full;
      assign round_idx = rd_round;
      assign sk_out    = bank_q;
   end else begin : g_on_the_fly
      logic loaded;
      logic step_ok;

      assign step_ok      = advance & loaded & ~load;
      assign lfsr_restart = load | (step_ok & gen_last);
      assign lfsr_step    = step_ok & ~gen_last;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            loaded    <= 1'b0;
            gen_round <= '0;
         end else if (load) begin
            loaded    <= 1'b1;
            gen_round <= '0;
         end else if (step_ok) begin
            gen_round <= gen_last ? '0 : gen_round + 1'b1;
         end
      end

      assign ready     = loaded;
      assign round_idx = gen_round;
      assign sk_out    = gen_sk;
   end

endmodule

// File: rtl/rsk_gen_chk.sv
module rsk_gen_chk #(
   parameter bit BANK = 1'b0,
   parameter int RW   = 5,
   parameter int OW   = 32
)(
   input logic           clk,
   input logic           rst_n,
   input logic           load,
   input logic           advance,
   input logic           ready,
   input logic [RW-1:0]  round_idx,
   input logic [OW-1:0]  sk_out
);

   localparam logic [RW-1:0] TOP = '1;

   // R6
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (round_idx == '0));

   // R6
   fly_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((BANK == 1'b0) && load) |=> ready);

   // R7
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && advance && !load && round_idx != TOP) |=> (round_idx == $past(round_idx) + 1'b1));

   // R7
   adv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && advance && !load && round_idx == TOP) |=> (round_idx == '0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !load) |=> $stable(round_idx));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !advance && !load) |=> ($stable(sk_out) && $stable(round_idx) && ready));

endmodule

bind rsk_gen rsk_gen_chk #(
   .BANK (BANK),
   .RW   (RW),
   .OW   (OW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .advance   (advance),
   .ready     (ready),
   .round_idx (round_idx),
   .sk_out    (sk_out)
);

// File: tb/sim_rsk_gen.sv
`timescale 1ns/1ps
module sim_rsk_gen;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld0 = 1'b0, ld1 = 1'b0;
   logic          adv0 = 1'b0, adv1 = 1'b0;
   logic [127:0]  key = '0;
   logic          rdy0, rdy1;
   logic [4:0]    ri0, ri1;
   logic [31:0]   sk0, sk1;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [6:0] dref [128];

   always #4 clk = ~clk;

   rsk_gen #(.BANK(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .load(ld0), .key_in(key), .advance(adv0),
      .ready(rdy0), .round_idx(ri0), .sk_out(sk0));

   rsk_gen #(.BANK(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .load(ld1), .key_in(key), .advance(adv1),
      .ready(rdy1), .round_idx(ri1), .sk_out(sk1));

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_sk(input logic [127:0] k, input int n);
      int i, j, b;
      logic [7:0] kb;
      i  = n / 16;
      j  = n % 8;
      b  = (((j - i) % 8) + 8) % 8 + (((n % 16) >= 8) ? 8 : 0);
      kb = k[8*b +: 8];
      return kb + {1'b0, dref[n]};
   endfunction

   function automatic logic [31:0] exp_round(input logic [127:0] k, input int r);
      logic [31:0] v;
      for (int l = 0; l < 4; l++) v[8*l +: 8] = exp_sk(k, 4*r + l);
      return v;
   endfunction

   task automatic do_load(input bit which, input logic [127:0] k);
      key = k;
      if (which) ld1 = 1'b1; else ld0 = 1'b1;
      tick();
      ld0 = 1'b0;
      ld1 = 1'b0;
   endtask

   task automatic do_adv(input bit which);
      if (which) adv1 = 1'b1; else adv0 = 1'b1;
      tick();
      adv0 = 1'b0;
      adv1 = 1'b0;
   endtask

   // full pass over all rounds, then the wrap back to round 0
   task automatic sweep(input bit which, input logic [127:0] k);
      for (int r = 0; r < 32; r++) begin
         chk("R7 round_idx", which ? ri1 : ri0, r);
         chk("R3 R4 R5 subkeys", which ? sk1 : sk0, exp_round(k, r));
         do_adv(which);
      end
      chk("R7 wrap round_idx", which ? ri1 : ri0, 0);
      chk("R7 wrap subkeys", which ? sk1 : sk0, exp_round(k, 0));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [133:0] s;
      logic [127:0] keys [6];
      bit r6_low_ok;
      // reference constants from the bit recurrence s(i+6) = s(i+2) ^ s(i-1)
      s = '0;
      s[6:0] = 7'h5A;
      for (int i = 1; i + 6 < 134; i++) s[i+6] = s[i+2] ^ s[i-1];
      for (int n = 0; n < 128; n++) dref[n] = s[n +: 7];

      keys[0] = '0;
      keys[1] = '1;
      for (int b = 0; b < 16; b++) keys[2][8*b +: 8] = 8'(b);
      for (int b = 0; b < 16; b++) keys[3][8*b +: 8] = 8'(8'hF0 - 8'(b * 17));
      for (int b = 0; b < 16; b++) keys[4][8*b +: 8] = 8'(b * 37 + 11);
      keys[5] = 128'h8000_0080_7F7F_FFA6_0102_0408_1020_4080;

      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 ready u0", rdy0, 0);
      chk("R1 ready u1", rdy1, 0);
      chk("R1 round_idx u0", ri0, 0);
      chk("R1 round_idx u1", ri1, 0);
      // R8 advance before any load
      do_adv(0);
      do_adv(1);
      chk("R8 no-load advance u0", {rdy0, ri0}, 0);
      chk("R8 no-load advance u1", {rdy1, ri1}, 0);

      // R6 banked fill timing, R8 advance during fill
      do_load(1, keys[2]);
      r6_low_ok = 1'b1;
      for (int c = 0; c < 32; c++) begin
         if (rdy1 !== 1'b0) r6_low_ok = 1'b0;
         adv1 = (c == 5);
         tick();
         adv1 = 1'b0;
      end
      chk("R6 banked ready low during fill", r6_low_ok, 1);
      chk("R6 banked ready at edge 32", rdy1, 1);
      chk("R8 advance during fill ignored", ri1, 0);

      // R6 on-the-fly ready next cycle
      do_load(0, keys[2]);
      chk("R6 fly ready after load", rdy0, 1);
      chk("R6 fly round_idx after load", ri0, 0);

      // R2 constants seen directly with a zero key
      do_load(0, keys[0]);
      chk("R2 SK0 zero key", sk0[7:0], 8'h5A);
      chk("R2 SK1..3 zero key", sk0[31:8], 24'h1B366D);
      for (int r = 0; r < 31; r++) do_adv(0);
      chk("R2 SK127 period", sk0[31:24], 8'h5A);

      // near-exhaustive sweeps
      for (int t = 0; t < 6; t++) begin
         for (int w = 0; w < 2; w++) begin
            do_load(w[0], keys[t]);
            if (w == 1) for (int c = 0; c < 32; c++) tick();
            sweep(w[0], keys[t]);
         end
      end

      // R9 hold without advance
      for (int w = 0; w < 2; w++) begin
         do_adv(w[0]);
         do_adv(w[0]);
         for (int c = 0; c < 4; c++) tick();
         chk("R9 hold round_idx", w ? ri1 : ri0, 2);
         chk("R9 hold subkeys", w ? sk1 : sk0, exp_round(keys[5], 2));
         chk("R9 hold ready", w ? rdy1 : rdy0, 1);
      end

      // R10 key_in change without load
      key = keys[3];
      tick();
      tick();
      chk("R10 key ignored u0", sk0, exp_round(keys[5], 2));
      chk("R10 key ignored u1", sk1, exp_round(keys[5], 2));
      do_adv(0);
      chk("R10 key ignored after advance", sk0, exp_round(keys[5], 3));

      // R6 reload mid-pass
      for (int c = 0; c < 5; c++) do_adv(0);
      do_load(0, keys[4]);
      chk("R6 reload round_idx", ri0, 0);
      chk("R6 reload subkeys", sk0, exp_round(keys[4], 0));
      do_adv(0);
      chk("R6 reload next round", sk0, exp_round(keys[4], 1));
      do_load(1, keys[4]);
      for (int c = 0; c < 32; c++) tick();
      chk("R6 banked reload subkeys", sk1, exp_round(keys[4], 0));
      chk("R6 banked reload round_idx", ri1, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule